// File: doc/BRIEF.md
# Stereo Block-SAD Disparity Search

This block turns two prefiltered camera streams into a depth map. Left and right image rows arrive as 16-bit samples in raster order, each stream with its own valid/ready handshake; the block takes one sample from each stream together. It keeps the most recent rows of both images in on-chip line memories. Once a full band of window rows is present, it searches the whole row: for every pixel it compares a square window of left samples against the same window in the right image, shifted left by each candidate disparity, and scores each candidate by a sum of absolute differences.

The candidate with the lowest score becomes the output for that pixel, as an unsigned disparity index with a one-cycle valid pulse. Only the winning index leaves the block; the costs stay inside it. While a row is being searched the inputs are held off. After that the next row is loaded and the band slides down by one row. After the last row of a frame the band is emptied, so the next frame starts clean.

The defaults are a 320 x 240 frame, 30 candidates and a 5 x 5 window. The window ends at the pixel being scored: it covers columns x-(WIN-1) to x and the WIN most recently loaded rows.

Top module: `sad_disparity_search`

## Requirements
- R1: After reset, d_valid is low, and with r_valid low, l_ready is low.
- R2: A sample pair is taken only when both l_valid and r_valid are high while the block is loading. l_ready is high only if r_valid is high, and r_ready is high only if l_valid is high.
- R3: While a row is being searched, l_ready and r_ready stay low.
- R4: For output pixel x and candidate d, the cost is the sum over the WIN most recent rows and the columns c = x-(WIN-1) .. x of |L[row][c] - R[row][c-d]|.
- R5: The output index is the candidate with the lowest cost. When costs are equal, the lower index wins.
- R6: A candidate d is scored only when x >= (WIN-1)+d. A pixel with no valid candidate (x < WIN-1) outputs index 0.
- R7: The cost accumulator is wide enough that WIN*WIN absolute differences at full scale (65535 each at the defaults) never wrap.
- R8: Every searched row produces exactly WIDTH outputs, one pulse per pixel, in increasing column order, and never on two cycles in a row. A frame of HEIGHT rows produces HEIGHT-WIN+1 output rows. The first output row of each frame follows its WIN-th input row.
- R9: Every output index is below NDISP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_valid | input | 1 | Left sample valid |
| l_ready | output | 1 | Left sample taken this cycle if l_valid |
| l_data | input | DW | Left filtered sample |
| r_valid | input | 1 | Right sample valid |
| r_ready | output | 1 | Right sample taken this cycle if r_valid |
| r_data | input | DW | Right filtered sample |
| d_valid | output | 1 | Disparity output valid pulse |
| d_index | output | DISPW | Winning disparity index |

## Verification
Four frame patterns are used. Full-range random data exercises the cost sum and the argmin in general. A right image built as the left image shifted by a known amount must give exactly that disparity once the shift becomes a valid candidate; pixels nearer the edge show how candidates are skipped. Flat, identical images make every cost equal, so they isolate the rule that the lower index wins a tie. Images made only of 0 and full-scale samples push costs toward the top of the accumulator, where any wrap would change which candidate wins. Once per row, one stream is made valid alone, which shows that ready is withheld until the two streams pair up.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [0:0] {ST_LOAD = 1'b0, ST_SEARCH = 1'b1} sad_state_e;
endpackage

// File: rtl/sad_line_ram.sv
module sad_line_ram #(
  parameter int DEPTH = 320,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sad_col_cost.sv
module sad_col_cost #(
  parameter int WIN  = 5,
  parameter int DW   = 16,
  localparam int COLW = DW + $clog2(WIN)
) (
  input  logic [WIN*DW-1:0] lft,
  input  logic [WIN*DW-1:0] rgt,
  output logic [COLW-1:0]   cost
);
  always_comb begin
    logic [DW-1:0] a, b;
    cost = '0;
    for (int i = 0; i < WIN; i++) begin
      a = lft[i*DW +: DW];
      b = rgt[i*DW +: DW];
      cost = cost + COLW'((a > b) ? (a - b) : (b - a));
    end
  end
endmodule

// File: rtl/sad_argmin.sv
module sad_argmin #(
  parameter int NDISP = 30,
  parameter int CW    = 21,
  localparam int DISPW = $clog2(NDISP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_final,
  input  logic             in_ok,
  input  logic [DISPW-1:0] in_idx,
  input  logic [CW-1:0]    in_cost,
  output logic             out_valid,
  output logic [DISPW-1:0] out_idx
);
  logic             have;
  logic [CW-1:0]    best_cost;
  logic [DISPW-1:0] best_idx;
  logic             have_base, take, n_have;
  logic [CW-1:0]    n_cost;
  logic [DISPW-1:0] n_idx;

  always_comb begin
    have_base = in_first ? 1'b0 : have;
    take      = in_ok && (!have_base || (in_cost < best_cost));
    n_have    = have_base || take;
    n_cost    = take ? in_cost : best_cost;
    n_idx     = take ? in_idx  : best_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have      <= 1'b0;
      best_cost <= '0;
      best_idx  <= '0;
      out_valid <= 1'b0;
      out_idx   <= '0;
    end else begin
      out_valid <= in_valid && in_final;
      if (in_valid) begin
        have      <= n_have;
        best_cost <= n_cost;
        best_idx  <= n_idx;
        if (in_final) out_idx <= n_have ? n_idx : '0;
      end
    end
  end

  // R5: an equal cost never displaces the lower index already held
  assert_tie_keeps_low_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_first && have && in_ok && in_cost == best_cost) |=> (best_idx == $past(best_idx)));

  // R9: output index inside the candidate range
  assert_idx_range_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_idx) < NDISP));
endmodule

// File: rtl/sad_disparity_search.sv
module sad_disparity_search
  import sad_pkg::*;
#(
  parameter int WIDTH  = 320,
  parameter int HEIGHT = 240,
  parameter int NDISP  = 30,
  parameter int WIN    = 5,
  parameter int DW     = 16,
  localparam int DISPW = $clog2(NDISP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             l_valid,
  output logic             l_ready,
  input  logic [DW-1:0]    l_data,
  input  logic             r_valid,
  output logic             r_ready,
  input  logic [DW-1:0]    r_data,
  output logic             d_valid,
  output logic [DISPW-1:0] d_index
);
  localparam int XW   = $clog2(WIDTH);
  localparam int HW   = $clog2(HEIGHT);
  localparam int KW   = $clog2(WIN);
  localparam int RHW  = $clog2(WIN + 1);
  localparam int COLW = DW + $clog2(WIN);
  localparam int CW   = DW + $clog2(WIN * WIN);
  localparam logic [XW-1:0]    X_LAST = XW'(WIDTH - 1);
  localparam logic [HW-1:0]    H_LAST = HW'(HEIGHT - 1);
  localparam logic [KW-1:0]    K_LAST = KW'(WIN - 1);
  localparam logic [DISPW-1:0] D_LAST = DISPW'(NDISP - 1);
  localparam logic [RHW-1:0]   R_FULL = RHW'(WIN);
  localparam logic [RHW-1:0]   R_GO   = RHW'(WIN - 1);

  sad_state_e       state;
  logic [XW-1:0]    col;
  logic [HW-1:0]    row_cnt;
  logic [RHW-1:0]   rows_have;
  logic [KW-1:0]    wr_slot;
  logic [XW-1:0]    sx;
  logic [DISPW-1:0] sd;
  logic [KW-1:0]    sk;
  logic             take, iss, ok;
  logic [XW-1:0]    laddr, raddr;

  assign l_ready = (state == ST_LOAD) && r_valid;
  assign r_ready = (state == ST_LOAD) && l_valid;
  assign take    = (state == ST_LOAD) && l_valid && r_valid;
  assign iss     = (state == ST_SEARCH);

  // read addresses for the current (x, d, k) step
  always_comb begin
    int xi, di, lc;
    xi = int'(sx);
    di = int'(sd);
    ok = xi >= (WIN - 1) + di;
    lc = xi - (WIN - 1) + int'(sk);
    laddr = ok ? XW'(lc)      : '0;
    raddr = ok ? XW'(lc - di) : '0;
  end

  // load and search sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_LOAD;
      col       <= '0;
      row_cnt   <= '0;
      rows_have <= '0;
      wr_slot   <= '0;
      sx        <= '0;
      sd        <= '0;
      sk        <= '0;
    end else if (state == ST_LOAD) begin
      if (take) begin
        col <= (col == X_LAST) ? '0 : col + 1'b1;
        if (col == X_LAST) begin
          row_cnt   <= (row_cnt == H_LAST) ? '0 : row_cnt + 1'b1;
          rows_have <= (row_cnt == H_LAST) ? '0 :
                       ((rows_have == R_FULL) ? R_FULL : rows_have + 1'b1);
          wr_slot   <= (row_cnt == H_LAST || wr_slot == K_LAST) ? '0 : wr_slot + 1'b1;
          if (rows_have >= R_GO) begin
            state <= ST_SEARCH;
            sx    <= '0;
            sd    <= '0;
            sk    <= '0;
          end
        end
      end
    end else begin
      sk <= (sk == K_LAST) ? '0 : sk + 1'b1;
      if (sk == K_LAST) begin
        sd <= (sd == D_LAST) ? '0 : sd + 1'b1;
        if (sd == D_LAST) begin
          sx <= (sx == X_LAST) ? '0 : sx + 1'b1;
          if (sx == X_LAST) state <= ST_LOAD;
        end
      end
    end
  end

  // line storage: one left and one right row memory per window row
  logic [WIN*DW-1:0] lcol_q, rcol_q;
  for (genvar g = 0; g < WIN; g++) begin : g_rows
    logic row_we;
    assign row_we = take && (wr_slot == KW'(g));
    sad_line_ram #(.DEPTH(WIDTH), .DW(DW)) u_lram (
      .clk(clk), .we(row_we), .waddr(col), .wdata(l_data),
      .re(iss), .raddr(laddr), .rdata(lcol_q[g*DW +: DW]));
    sad_line_ram #(.DEPTH(WIDTH), .DW(DW)) u_rram (
      .clk(clk), .we(row_we), .waddr(col), .wdata(r_data),
      .re(iss), .raddr(raddr), .rdata(rcol_q[g*DW +: DW]));
  end

  // stage 1 tags, aligned with the memory read data
  logic             p1_v, p1_first, p1_last, p1_ok, p1_d0, p1_dlast;
  logic [DISPW-1:0] p1_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_v     <= 1'b0;
      p1_first <= 1'b0;
      p1_last  <= 1'b0;
      p1_ok    <= 1'b0;
      p1_d0    <= 1'b0;
      p1_dlast <= 1'b0;
      p1_d     <= '0;
    end else begin
      p1_v     <= iss;
      p1_first <= (sk == '0);
      p1_last  <= (sk == K_LAST);
      p1_ok    <= ok;
      p1_d0    <= (sd == '0);
      p1_dlast <= (sd == D_LAST);
      p1_d     <= sd;
    end
  end

  logic [COLW-1:0] colcost;
  logic [CW-1:0]   acc, acc_sum;

  sad_col_cost #(.WIN(WIN), .DW(DW)) u_colcost (
    .lft(lcol_q), .rgt(rcol_q), .cost(colcost));

  assign acc_sum = (p1_first ? '0 : acc) + CW'(colcost);

  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (p1_v) acc <= acc_sum;
  end

  sad_argmin #(.NDISP(NDISP), .CW(CW)) u_argmin (
    .clk(clk), .rst(rst),
    .in_valid(p1_v && p1_last), .in_first(p1_d0), .in_final(p1_dlast),
    .in_ok(p1_ok), .in_idx(p1_d), .in_cost(acc_sum),
    .out_valid(d_valid), .out_idx(d_index));

  // R2: ready on one side only when the other side is valid
  assert_ready_pair_R2: assert property (@(posedge clk) disable iff (rst)
    (l_ready |-> r_valid) and (r_ready |-> l_valid));

  // R3: no sample taken during a row search
  assert_no_accept_search_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEARCH) |-> (!l_ready && !r_ready));

  // R7: the running window sum never wraps
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (p1_v && !p1_first) |-> (acc_sum >= acc));

  // R8: outputs are single-cycle pulses
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    d_valid |=> !d_valid);
endmodule

// File: tb/sad_disparity_search_bench.sv
module sad_disparity_search_bench;
  localparam int W  = 16;
  localparam int H  = 7;
  localparam int ND = 6;
  localparam int WN = 5;
  localparam int DW = 16;
  localparam int DISPW = $clog2(ND);
  localparam int NFR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_valid = 1'b0, r_valid = 1'b0;
  logic l_ready, r_ready;
  logic [DW-1:0] l_data = '0, r_data = '0;
  logic d_valid;
  logic [DISPW-1:0] d_index;

  always #5 clk = ~clk;

  sad_disparity_search #(.WIDTH(W), .HEIGHT(H), .NDISP(ND), .WIN(WN), .DW(DW)) u_sad_disparity_search (
    .clk(clk), .rst(rst),
    .l_valid(l_valid), .l_ready(l_ready), .l_data(l_data),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data),
    .d_valid(d_valid), .d_index(d_index));

  int checks = 0, fails = 0, outs = 0;
  bit done = 0;
  int exp_q[$];
  int imgl [H][W];
  int imgr [H][W];

  task automatic check(input bit cond, input string req, input int act, input int expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // reference: R4 cost, R5 argmin with low-index ties, R6 edge skipping
  function automatic int ref_idx(input int y, input int x);
    longint best = 0, cost;
    int bi = 0;
    bit have = 0;
    for (int d = 0; d < ND; d++) begin
      if (x >= WN - 1 + d) begin
        cost = 0;
        for (int rr = y - WN + 1; rr <= y; rr++)
          for (int c = x - WN + 1; c <= x; c++) begin
            int df;
            df = imgl[rr][c] - imgr[rr][c - d];
            cost += (df < 0) ? -df : df;
          end
        if (!have || cost < best) begin
          best = cost; bi = d; have = 1;
        end
      end
    end
    return bi;
  endfunction

  task automatic fill_frame(input int kind);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        case (kind)
          0: begin imgl[y][x] = $urandom & 16'hFFFF; imgr[y][x] = $urandom & 16'hFFFF; end
          1: imgl[y][x] = $urandom % 4000;
          2: begin imgl[y][x] = 1234; imgr[y][x] = 1234; end
          default: begin
            imgl[y][x] = ($urandom & 1) ? 16'hFFFF : 0;
            imgr[y][x] = ($urandom & 1) ? 16'hFFFF : 0;
          end
        endcase
      end
    if (kind == 1)
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++)
          imgr[y][x] = (x + 3 < W) ? imgl[y][x + 3] : ($urandom % 4000);
  endtask

  // driver: sends one row, pushes the expected outputs of a full band
  task automatic send_row(input int y);
    for (int c = 0; c < W; c++) begin
      @(negedge clk);
      l_data = imgl[y][c][DW-1:0];
      r_data = imgr[y][c][DW-1:0];
      if (c == 1) begin
        l_valid = 1'b1; r_valid = 1'b0;
        #1;
        check(l_ready == 1'b0, "R2 left alone not taken", int'(l_ready), 0);
        @(negedge clk);
      end
      l_valid = 1'b1; r_valid = 1'b1;
      #1;
      while (!l_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    l_valid = 1'b0; r_valid = 1'b0;
    if (y >= WN - 1)
      for (int x = 0; x < W; x++) exp_q.push_back(ref_idx(y, x));
  endtask

  // monitor: R5 R6 R8 R9 checked against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && d_valid) begin
      outs++;
      check(int'(d_index) < ND, "R9 index range", int'(d_index), ND - 1);
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected output", int'(d_index), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(int'(d_index) == e, "R4 R5 R6 disparity", int'(d_index), e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(d_valid == 1'b0, "R1 d_valid after reset", int'(d_valid), 0);
    check(l_ready == 1'b0, "R1 l_ready after reset", int'(l_ready), 0);
    for (int f = 0; f < NFR; f++) begin
      fill_frame(f);
      for (int y = 0; y < H; y++) begin
        send_row(y);
        if (y == WN - 2) begin
          repeat (3 * W) @(negedge clk);
          check(exp_q.size() == 0 && outs == f * (H - WN + 1) * W,
                "R8 no output before band full", outs, f * (H - WN + 1) * W);
        end
      end
    end
    repeat (ND * WN * W * 2 + 50) @(negedge clk);
    check(exp_q.size() == 0, "R8 all rows emitted", exp_q.size(), 0);
    check(outs == NFR * (H - WN + 1) * W, "R8 output count", outs, NFR * (H - WN + 1) * W);
    finish_run();
  end
endmodule